// File: doc/BRIEF.md
# Stream-to-Memory Write Engine

This peripheral drains a ready/valid stream of 64-bit words into a region of memory that software describes. Software reaches four 64-bit control words through a simple read/write register port. The port decodes a 64-byte window that sits at a configurable base. Software writes a destination byte address and a byte count, then writes a 1 to the run flag. The engine then emits one memory write request per input word, with address, data and byte enables, under a valid/ready handshake.

When the last byte has been accepted by memory, the engine drops the run flag and raises the done flag. Software polls the done flag and clears it. A final word that only partly fills the count is written with its upper byte enables off.

Top module: `strm2mem_writer`

## Requirements
- R1: After reset the run flag and the done flag both read 0, `inReady` is 0 and `memValid` is 0.
- R2: An access hits the block when `busAddr` equals `BASE_ADDR` on every bit above the low 6. Bits [5:3] select a word: 0 is the destination address, 1 is the byte count, 2 is the run flag in bit 0, and 3 is the done flag in bit 0. Bits [2:0] are ignored. Selectors 4 to 7 read 0 and ignore writes. Accesses outside the window ignore writes and read 0.
- R3: The destination and count words read back the last value written to them, with all 64 bits. Neither a transfer nor a write to them while a transfer is active changes what that transfer does.
- R4: Writing a word with bit 0 set to the run flag while idle starts a transfer: the run flag reads 1 and the done flag reads 0 from the next cycle. Any write to the run flag while a transfer is active has no effect.
- R5: `inReady` is 1 only while a transfer is active, bytes remain and no memory request is outstanding. `inReady` and `memValid` are never 1 together.
- R6: Each accepted input word produces exactly one memory request, one cycle later. The first request targets the programmed address, and each later one targets 8 bytes above the previous one. A request holds its address, data and enables until `memReady` is seen.
- R7: `memStrb` bit i enables byte i of `memData`. It is 8'hFF while 8 or more bytes remain. When n < 8 bytes remain, only the low n bits of `memStrb` are set, and the rest of that input word is dropped.
- R8: The cycle after the last request is accepted, the run flag reads 0 and the done flag reads 1. With a count of 0, this happens one cycle after the start, and no memory request is made.
- R9: Writing 0 in bit 0 of the done flag clears it. Writing 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 64 | Register byte address |
| busWdata | input | 64 | Register write data |
| busRdata | output | 64 | Register read data, same cycle as the access |
| inValid | input | 1 | Stream word present |
| inData | input | 64 | Stream word |
| inReady | output | 1 | Engine takes the stream word this cycle |
| memValid | output | 1 | Memory write request present |
| memReady | input | 1 | Memory takes the request this cycle |
| memAddr | output | 64 | Request byte address |
| memData | output | 64 | Request data |
| memStrb | output | 8 | Request byte enables |

## Verification
Register reads are combinational, so the bench samples them 1 ns after driving the address, before any edge. A register write takes effect at the next rising edge, and the run and done flags move there. An accepted stream word becomes a memory request one edge later. Completion shows two edges after the handshake of the last request, or one edge after a start with a count of 0. The bench counts falling edges from the start and requires the done flag on exactly that falling edge, not merely eventually.

// File: rtl/strm2mem_pkg.sv
package strm2mem_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_ISSUE = 2'd2
  } engState_t;

  typedef struct packed {
    logic start;    // load working pointers from programmed words
    logic capture;  // stream word taken into the beat register
    logic advance;  // memory took the outstanding beat
    logic wrDest;   // software writes the destination word
    logic wrLen;    // software writes the byte count word
  } ctrlStrb_t;

endpackage

// File: rtl/s2m_ctrl.sv
module s2m_ctrl
  import strm2mem_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 64'h0000_0000_4000_0000,
  parameter int WIN_BITS = 6,
  parameter int SEL_LSB = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 wrBit,
  input  logic                 inValid,
  input  logic                 memReady,
  input  logic                 remZero,
  output ctrlStrb_t            strb,
  output logic                 hit,
  output logic [WIN_BITS-SEL_LSB-1:0] regSel,
  output logic                 inReady,
  output logic                 memValid,
  output logic                 running,
  output logic                 complete
);

  localparam int SEL_W = WIN_BITS - SEL_LSB;
  localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((64'd1 << WIN_BITS) - 64'd1);
  localparam logic [SEL_W-1:0] SEL_DEST = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_LEN  = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_RUN  = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_DONE = SEL_W'(3);

  engState_t state;
  logic      wrHit;
  logic      startReq;

  assign hit      = ((busAddr ^ BASE_ADDR) & ~WIN_MASK) == '0;
  assign regSel   = busAddr[WIN_BITS-1:SEL_LSB];
  assign wrHit    = busValid && busWrite && hit;
  assign startReq = wrHit && (regSel == SEL_RUN) && wrBit && (state == S_IDLE);

  assign running  = (state != S_IDLE);
  assign inReady  = (state == S_FETCH) && !remZero;
  assign memValid = (state == S_ISSUE);

  always_comb begin
    strb         = '0;
    strb.start   = startReq;
    strb.capture = inReady && inValid;
    strb.advance = memValid && memReady;
    strb.wrDest  = wrHit && (regSel == SEL_DEST);
    strb.wrLen   = wrHit && (regSel == SEL_LEN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      complete <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE:  if (startReq) state <= S_FETCH;
        S_FETCH: begin
          if (remZero)      state <= S_IDLE;
          else if (inValid) state <= S_ISSUE;
        end
        S_ISSUE: if (memReady) state <= S_FETCH;
        default: state <= S_IDLE;
      endcase

      if (startReq)
        complete <= 1'b0;
      else if (state == S_FETCH && remZero)
        complete <= 1'b1;
      else if (wrHit && regSel == SEL_DONE && !wrBit)
        complete <= 1'b0;
    end
  end

  a_r5_ready_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> running);
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && memValid));
  a_r8_done_with_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(complete) |-> $fell(running));
  a_r4_start_effect: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> running && !complete);
  a_r9_set_only_by_engine: assert property (@(posedge clk) disable iff (!rstN)
    (!complete && !(state == S_FETCH && remZero)) |=> !complete);

endmodule

// File: rtl/s2m_path.sv
module s2m_path
  import strm2mem_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [63:0]       busWdata,
  input  logic [DATA_W-1:0] inData,
  output logic [ADDR_W-1:0] progDest,
  output logic [LEN_W-1:0]  progLen,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [DATA_W/8-1:0] memStrb,
  output logic              remZero
);

  localparam int BYTES  = DATA_W / 8;
  localparam int STRB_W = BYTES;
  localparam int SH     = $clog2(BYTES);

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic [DATA_W-1:0] beatData;
  logic              lastPartial;

  assign remZero     = (remLen == '0);
  assign lastPartial = (remLen < LEN_W'(BYTES));
  assign memAddr     = curAddr;
  assign memData     = beatData;
  assign memStrb     = lastPartial
                     ? ((STRB_W'(1) << remLen[SH-1:0]) - STRB_W'(1))
                     : '1;

  // Programmed words and the beat register carry no reset.
  always_ff @(posedge clk) begin
    if (strb.wrDest)  progDest <= ADDR_W'(busWdata);
    if (strb.wrLen)   progLen  <= LEN_W'(busWdata);
    if (strb.capture) beatData <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remLen  <= '0;
    end else if (strb.start) begin
      curAddr <= progDest;
      remLen  <= progLen;
    end else if (strb.advance) begin
      curAddr <= curAddr + ADDR_W'(BYTES);
      remLen  <= lastPartial ? '0 : remLen - LEN_W'(BYTES);
    end
  end

  a_r7_strb_low_run: assert property (@(posedge clk) disable iff (!rstN)
    !remZero |-> (memStrb != '0) && (((memStrb + STRB_W'(1)) & memStrb) == '0));
  a_r3_prog_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.wrDest) |=> $stable(progDest));

endmodule

// File: rtl/strm2mem_writer.sv
module strm2mem_writer
  import strm2mem_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 64,
  parameter int DATA_W = 64,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 64'h0000_0000_4000_0000,
  parameter int WIN_BITS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [63:0]         busWdata,
  output logic [63:0]         busRdata,
  input  logic                inValid,
  input  logic [DATA_W-1:0]   inData,
  output logic                inReady,
  output logic                memValid,
  input  logic                memReady,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memData,
  output logic [DATA_W/8-1:0] memStrb
);

  localparam int SEL_LSB = 3;
  localparam int SEL_W   = WIN_BITS - SEL_LSB;

  ctrlStrb_t         strb;
  logic              hit;
  logic [SEL_W-1:0]  regSel;
  logic              running;
  logic              complete;
  logic              remZero;
  logic [ADDR_W-1:0] progDest;
  logic [LEN_W-1:0]  progLen;

  s2m_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS), .SEL_LSB(SEL_LSB)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .wrBit(busWdata[0]),
    .inValid(inValid), .memReady(memReady), .remZero(remZero),
    .strb(strb), .hit(hit), .regSel(regSel),
    .inReady(inReady), .memValid(memValid), .running(running), .complete(complete)
  );

  s2m_path #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .inData(inData),
    .progDest(progDest), .progLen(progLen),
    .memAddr(memAddr), .memData(memData), .memStrb(memStrb), .remZero(remZero)
  );

  always_comb begin
    busRdata = '0;
    if (busValid && hit) begin
      case (regSel)
        SEL_W'(0): busRdata = 64'(progDest);
        SEL_W'(1): busRdata = 64'(progLen);
        SEL_W'(2): busRdata = {63'd0, running};
        SEL_W'(3): busRdata = {63'd0, complete};
        default:   busRdata = '0;
      endcase
    end
  end

  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=>
      memValid && $stable(memAddr) && $stable(memData) && $stable(memStrb));
  a_r6_one_beat_per_word: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> memValid);

endmodule

// File: tb/sim_strm2mem_writer.sv
module sim_strm2mem_writer;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] BASE = 64'h0000_0000_4000_0000;

  typedef struct packed {
    logic [63:0] dest;
    logic [63:0] len;
    logic        bp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{dest: 64'h0000_0000_8000_0000, len: 64'd24, bp: 1'b0},
    '{dest: 64'h0000_0000_8000_1008, len: 64'd13, bp: 1'b1},
    '{dest: 64'h0000_0000_0000_0040, len: 64'd5,  bp: 1'b0},
    '{dest: 64'h0000_0000_0000_0200, len: 64'd0,  bp: 1'b0},
    '{dest: 64'hFFFF_0000_0000_0100, len: 64'd17, bp: 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [63:0] busAddr = '0, busWdata = '0, busRdata;
  logic        inValid = 1'b0;
  logic [63:0] inData = '0;
  logic        inReady, memValid;
  logic        memReady = 1'b0;
  logic [63:0] memAddr, memData;
  logic [7:0]  memStrb;

  int checks = 0;
  int errors = 0;
  int tag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strm2mem_writer #(.BASE_ADDR(BASE)) u0 (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .memValid(memValid), .memReady(memReady),
    .memAddr(memAddr), .memData(memData), .memStrb(memStrb)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [63:0] a, input logic [63:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regRd(input logic [63:0] a, output logic [63:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busValid = 1'b0;
  endtask

  function automatic logic [63:0] wordOf(input int t, input int i);
    return {8'(t), 24'hA5C3E1, 32'(i)};
  endfunction

  function automatic logic [7:0] strbOf(input logic [63:0] rem);
    return (rem >= 64'd8) ? 8'hFF : 8'((9'd1 << rem[2:0]) - 9'd1);
  endfunction

  // Feeds the stream and acts as memory until done is seen. The start write
  // must have just completed; iteration 0 is the first falling edge after it.
  task automatic runStream(input logic [63:0] dest, input logic [63:0] len, input logic bp);
    int sent = 0;
    int beats = 0;
    int lastBeat = -1;
    int doneAt = -1;
    bit overlap = 0;
    logic [63:0] rd;
    int nBeats = int'((len + 64'd7) >> 3);
    for (int it = 0; it < 400 && doneAt < 0; it++) begin
      @(negedge clk);
      inValid  = 1'b1;
      inData   = wordOf(tag, sent);
      memReady = bp ? it[0] : 1'b1;
      #1;
      if (inReady && memValid) overlap = 1;
      if (memValid && memReady) begin
        chk("R6 beat address", memAddr, dest + 64'(beats * 8));
        chk("R6 beat data", memData, wordOf(tag, beats));
        chk("R7 beat strobe", 64'(memStrb), 64'(strbOf(len - 64'(beats * 8))));
        beats++;
        lastBeat = it;
      end
      if (inValid && inReady) sent++;
      regRd(BASE + 64'h18, rd);
      if (rd[0]) doneAt = it;
    end
    inValid = 1'b0; memReady = 1'b0;
    chk("R6 beat count", 64'(beats), 64'(nBeats));
    chk("R6 word count", 64'(sent), 64'(nBeats));
    chk("R5 ready/valid never together", 64'(overlap), 64'd0);
    if (len == 0) chk("R8 zero count done timing", 64'(doneAt), 64'd1);
    else          chk("R8 done timing", 64'(doneAt), 64'(lastBeat + 2));
    regRd(BASE + 64'h10, rd);
    chk("R8 run clears", rd, 64'd0);
    chk("R5 ready low when idle", 64'(inReady), 64'd0);
    tag++;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [63:0] rd;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRd(BASE + 64'h10, rd); chk("R1 run after reset", rd, 64'd0);
    regRd(BASE + 64'h18, rd); chk("R1 done after reset", rd, 64'd0);
    chk("R1 inReady after reset", 64'(inReady), 64'd0);
    chk("R1 memValid after reset", 64'(memValid), 64'd0);

    // Vector table
    for (int v = 0; v < 5; v++) begin
      regWr(BASE + 64'h00, VECS[v].dest);
      regWr(BASE + 64'h08, VECS[v].len);
      regWr(BASE + 64'h10, 64'd1);
      runStream(VECS[v].dest, VECS[v].len, VECS[v].bp);
      regRd(BASE + 64'h00, rd); chk("R3 dest readback", rd, VECS[v].dest);
      regRd(BASE + 64'h08, rd); chk("R3 count readback", rd, VECS[v].len);
    end

    // R9 done flag: a 1 is ignored, a 0 clears
    regRd(BASE + 64'h18, rd); chk("R9 done held", rd, 64'd1);
    regWr(BASE + 64'h18, 64'd1);
    regRd(BASE + 64'h18, rd); chk("R9 write 1 ignored", rd, 64'd1);
    regWr(BASE + 64'h18, 64'd0);
    regRd(BASE + 64'h18, rd); chk("R9 write 0 clears", rd, 64'd0);

    // R2 window decode
    regWr(BASE + 64'h00, 64'h1111_2222_3333_4440);
    regWr(BASE + 64'h40, 64'hDEAD_BEEF_0000_0000);
    regRd(BASE + 64'h00, rd); chk("R2 outside write ignored", rd, 64'h1111_2222_3333_4440);
    regRd(BASE + 64'h40, rd); chk("R2 outside read zero", rd, 64'd0);
    regRd(BASE + 64'h28, rd); chk("R2 unused selector zero", rd, 64'd0);
    regWr(BASE + 64'h08, 64'h0000_0000_0000_0BAD);
    regRd(BASE + 64'h0C, rd); chk("R2 low bits ignored", rd, 64'h0000_0000_0000_0BAD);
    regWr(BASE + 64'h1000_0010, 64'd1);
    regRd(BASE + 64'h10, rd); chk("R2 outside start ignored", rd, 64'd0);

    // R4 start clears done; zero count done after one cycle
    regWr(BASE + 64'h08, 64'd0);
    regWr(BASE + 64'h10, 64'd1);
    @(negedge clk);
    regRd(BASE + 64'h10, rd); chk("R4 run set by start", rd, 64'd1);
    regRd(BASE + 64'h18, rd); chk("R8 zero count not yet done", rd, 64'd0);
    @(negedge clk);
    regRd(BASE + 64'h18, rd); chk("R8 zero count done", rd, 64'd1);
    regWr(BASE + 64'h08, 64'd16);
    regWr(BASE + 64'h10, 64'd1);
    @(negedge clk);
    regRd(BASE + 64'h18, rd); chk("R4 start clears done", rd, 64'd0);

    // R4 and R3: writes during an active transfer change nothing
    regWr(BASE + 64'h10, 64'd0);
    regRd(BASE + 64'h10, rd); chk("R4 run write 0 ignored", rd, 64'd1);
    regWr(BASE + 64'h10, 64'd1);
    regWr(BASE + 64'h00, 64'h0000_0000_0000_7000);
    regWr(BASE + 64'h08, 64'd3);
    regRd(BASE + 64'h00, rd); chk("R3 dest rewritten", rd, 64'h0000_0000_0000_7000);
    runStream(64'h1111_2222_3333_4440, 64'd16, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule